// File: doc/BRIEF.md
# Per-Channel Frame Sequence Checker

This block sits in front of the decrypt and authenticate stage of a secured configuration port. Each incoming frame is parsed upstream into a channel slot index and a frame sequence counter. The counter is the low four bytes of the frame's twelve-byte nonce; the other eight bytes are random. The block keeps one expected counter per configured channel. It compares the frame's counter with the counter expected for that slot. On a match it issues a pass verdict so the frame can go on to decryption. On a mismatch it issues a drop verdict and raises an error-reply descriptor. That descriptor repeats the rejected counter, so the reply carries the same frame number as the request. It also reports the counter the sender should have used. The downstream formatter places that expected counter at the head of the plaintext reply payload and pads it with fourteen zero bytes.

An expected counter moves forward only when the authenticate stage later reports success for that slot on the commit input. A forged frame that carries the right counter therefore cannot advance it. Counters wrap from their all-ones value to zero. The block evaluates at most one header per clock. It stops accepting headers while an error reply waits on its output.

Control is a two-state machine. `ST_ACCEPT` is entered at reset. Headers are taken in this state, and a matching header keeps the machine there. A mismatching header moves it to `ST_REPLY`. `ST_REPLY` holds the reply descriptor until the reply handshake completes, then returns to `ST_ACCEPT`.

Top module: `frame_seq_gate`

## Requirements
- R1: After reset every slot's expected counter is zero, `hdr_ready` is 1, and `verdict_valid` and `rep_valid` are 0.
- R2: A header accepted with `hdr_fnum` equal to its slot's expected counter gives `verdict_valid`=1 and `verdict_pass`=1 in the cycle after the handshake, with no reply raised.
- R3: A header accepted with `hdr_fnum` different from its slot's expected counter gives `verdict_valid`=1 and `verdict_pass`=0 in the cycle after the handshake. In the same cycle `rep_valid` goes to 1, with `rep_echo` equal to the rejected `hdr_fnum` and `rep_expect` equal to the slot's expected counter.
- R4: A slot's expected counter rises by one only on a cycle with `commit_valid`=1 and `commit_slot` naming that slot. Other slots are unaffected, and pass verdicts without a commit leave every counter unchanged.
- R5: A commit on a slot whose expected counter is all ones (2^CNT_W-1) sets that counter to zero.
- R6: While `rep_valid`=1 and `rep_ready`=0, `hdr_ready` is 0, no header is taken and no verdict is issued, and `rep_echo` and `rep_expect` hold their values.
- R7: In the cycle after a handshake with `rep_valid`=1 and `rep_ready`=1, `rep_valid` is 0 and `hdr_ready` is 1.
- R8: `verdict_valid` is 1 in exactly the cycles that follow a header handshake (`hdr_valid`=1 and `hdr_ready`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Parsed header present |
| hdr_ready | output | 1 | Block can take a header |
| hdr_slot | input | SLOT_W | Channel slot index of the header |
| hdr_fnum | input | CNT_W | Frame sequence counter of the header (32 bits by default) |
| verdict_valid | output | 1 | Verdict strobe, one cycle per accepted header |
| verdict_pass | output | 1 | 1 = forward to decrypt, 0 = drop |
| commit_valid | input | 1 | Authentication succeeded for a passed frame |
| commit_slot | input | SLOT_W | Slot whose counter advances |
| rep_valid | output | 1 | Error-reply descriptor present |
| rep_ready | input | 1 | Reply consumer can take the descriptor |
| rep_echo | output | CNT_W | Rejected frame counter, copied back into the reply |
| rep_expect | output | CNT_W | Counter the sender should use next |

## Verification
Verdicts and reply descriptors are registered. Each one is due in the first cycle after the clock edge that completes the header handshake, and commits show up in the verdict of the first header taken after the commit edge. The bench drives inputs on the falling edge and samples one nanosecond after the rising edge that completes each handshake, so each result is read in the cycle it is due. It builds a four-slot, four-bit-counter instance and sweeps every counter value on every slot. Expected counters are kept in a bench array that advances modulo 16 on each commit.

// File: rtl/seqchk_pkg.sv
package seqchk_pkg;
    typedef enum logic [0:0] {
        ST_ACCEPT = 1'b0,
        ST_REPLY  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/seqchk_cnt_bank.sv
module seqchk_cnt_bank #(
    parameter int NUM_SLOTS = 4,
    parameter int CNT_W     = 32,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [CNT_W-1:0]  rd_value,
    input  logic              inc_en,
    input  logic [SLOT_W-1:0] inc_slot
);
    logic [CNT_W-1:0] cnt_arr [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_arr[g] <= '0;
            end else if (inc_en && (inc_slot == SLOT_W'(g))) begin
                cnt_arr[g] <= cnt_arr[g] + CNT_W'(1);
            end
        end
    end

    always_comb begin
        rd_value = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_slot == SLOT_W'(i)) rd_value = cnt_arr[i];
        end
    end
endmodule

// File: rtl/seqchk_ctrl.sv
module seqchk_ctrl
    import seqchk_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_valid,
    input  logic [CNT_W-1:0] hdr_fnum,
    input  logic [CNT_W-1:0] exp_value,
    output logic             hdr_ready,
    output logic             verdict_valid,
    output logic             verdict_pass,
    output logic             rep_valid,
    input  logic             rep_ready,
    output logic [CNT_W-1:0] rep_echo,
    output logic [CNT_W-1:0] rep_expect
);
    seq_state_e state_q, state_d;
    logic       take_hdr;
    logic       fnum_ok;

    assign take_hdr  = hdr_valid && (state_q == ST_ACCEPT);
    assign fnum_ok   = (hdr_fnum == exp_value);
    assign hdr_ready = (state_q == ST_ACCEPT);
    assign rep_valid = (state_q == ST_REPLY);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCEPT: if (take_hdr && !fnum_ok) state_d = ST_REPLY;
            ST_REPLY:  if (rep_ready)            state_d = ST_ACCEPT;
            default:                             state_d = ST_ACCEPT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACCEPT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_valid <= 1'b0;
            verdict_pass  <= 1'b0;
            rep_echo      <= '0;
            rep_expect    <= '0;
        end else begin
            verdict_valid <= take_hdr;
            verdict_pass  <= take_hdr && fnum_ok;
            if (take_hdr && !fnum_ok) begin
                rep_echo   <= hdr_fnum;
                rep_expect <= exp_value;
            end
        end
    end
endmodule

// File: rtl/frame_seq_gate.sv
module frame_seq_gate #(
    parameter int NUM_SLOTS = 4,
    parameter int CNT_W     = 32,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_valid,
    output logic              hdr_ready,
    input  logic [SLOT_W-1:0] hdr_slot,
    input  logic [CNT_W-1:0]  hdr_fnum,
    output logic              verdict_valid,
    output logic              verdict_pass,
    input  logic              commit_valid,
    input  logic [SLOT_W-1:0] commit_slot,
    output logic              rep_valid,
    input  logic              rep_ready,
    output logic [CNT_W-1:0]  rep_echo,
    output logic [CNT_W-1:0]  rep_expect
);
    logic [CNT_W-1:0] exp_value;

    seqchk_cnt_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .CNT_W     (CNT_W),
        .SLOT_W    (SLOT_W)
    ) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_slot  (hdr_slot),
        .rd_value (exp_value),
        .inc_en   (commit_valid),
        .inc_slot (commit_slot)
    );

    seqchk_ctrl #(
        .CNT_W (CNT_W)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .hdr_valid     (hdr_valid),
        .hdr_fnum      (hdr_fnum),
        .exp_value     (exp_value),
        .hdr_ready     (hdr_ready),
        .verdict_valid (verdict_valid),
        .verdict_pass  (verdict_pass),
        .rep_valid     (rep_valid),
        .rep_ready     (rep_ready),
        .rep_echo      (rep_echo),
        .rep_expect    (rep_expect)
    );
endmodule

// File: rtl/seqchk_chk.sv
module seqchk_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hdr_valid,
    input logic             hdr_ready,
    input logic             verdict_valid,
    input logic             verdict_pass,
    input logic             rep_valid,
    input logic             rep_ready,
    input logic [CNT_W-1:0] rep_echo,
    input logic [CNT_W-1:0] rep_expect
);
    // R8
    verdict_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready) |=> verdict_valid);

    // R8
    no_stray_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_valid && hdr_ready) |=> !verdict_valid);

    // R3
    drop_raises_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && !verdict_pass) |-> (rep_valid && (rep_echo != rep_expect)));

    // R2
    pass_no_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && verdict_pass) |-> !rep_valid);

    // R6
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |-> !hdr_ready);

    // R6
    stall_holds_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && !rep_ready) |=> (rep_valid && $stable(rep_echo) && $stable(rep_expect)));

    // R7
    reply_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && rep_ready) |=> (!rep_valid && hdr_ready));
endmodule

bind frame_seq_gate seqchk_chk #(.CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .hdr_valid     (hdr_valid),
    .hdr_ready     (hdr_ready),
    .verdict_valid (verdict_valid),
    .verdict_pass  (verdict_pass),
    .rep_valid     (rep_valid),
    .rep_ready     (rep_ready),
    .rep_echo      (rep_echo),
    .rep_expect    (rep_expect)
);

// File: tb/frame_seq_gate_tb_top.sv
`timescale 1ns/1ps
module frame_seq_gate_tb_top;
    localparam int NS = 4;
    localparam int CW = 4;
    localparam int SW = 2;
    localparam int MODV = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hdr_valid = 1'b0;
    logic          hdr_ready;
    logic [SW-1:0] hdr_slot = '0;
    logic [CW-1:0] hdr_fnum = '0;
    logic          verdict_valid, verdict_pass;
    logic          commit_valid = 1'b0;
    logic [SW-1:0] commit_slot = '0;
    logic          rep_valid;
    logic          rep_ready = 1'b0;
    logic [CW-1:0] rep_echo, rep_expect;

    int n_chk = 0;
    int n_fail = 0;
    int exp_cnt [NS];
    bit finished = 1'b0;

    always #2 clk = ~clk;

    frame_seq_gate #(.NUM_SLOTS(NS), .CNT_W(CW), .SLOT_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_slot(hdr_slot), .hdr_fnum(hdr_fnum),
        .verdict_valid(verdict_valid), .verdict_pass(verdict_pass),
        .commit_valid(commit_valid), .commit_slot(commit_slot),
        .rep_valid(rep_valid), .rep_ready(rep_ready),
        .rep_echo(rep_echo), .rep_expect(rep_expect)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic commit(input int s);
        @(negedge clk);
        commit_valid = 1'b1; commit_slot = SW'(s);
        step();
        commit_valid = 1'b0;
        exp_cnt[s] = (exp_cnt[s] + 1) % MODV;
    endtask

    task automatic send(input int s, input int f, input string req);
        bit good;
        good = (f == exp_cnt[s]);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_slot = SW'(s); hdr_fnum = CW'(f);
        step();
        hdr_valid = 1'b0;
        chk(verdict_valid == 1'b1, {req, " R8 verdict strobe"}, int'(verdict_valid), 1);
        chk(verdict_pass == good, {req, " verdict"}, int'(verdict_pass), int'(good));
        chk(rep_valid == !good, {req, " reply raised"}, int'(rep_valid), int'(!good));
        if (!good) begin
            chk(rep_echo == CW'(f), "R3 echo", int'(rep_echo), f);
            chk(rep_expect == CW'(exp_cnt[s]), "R3 expect", int'(rep_expect), exp_cnt[s]);
            // R6: stall with a new header waiting
            @(negedge clk);
            hdr_valid = 1'b1; hdr_fnum = CW'(exp_cnt[s]);
            for (int k = 0; k < 2; k++) begin
                step();
                chk(hdr_ready == 1'b0, "R6 ready low", int'(hdr_ready), 0);
                chk(verdict_valid == 1'b0, "R6 no verdict", int'(verdict_valid), 0);
                chk(rep_valid && rep_echo == CW'(f) && rep_expect == CW'(exp_cnt[s]),
                    "R6 reply held", int'(rep_echo), f);
            end
            @(negedge clk);
            hdr_valid = 1'b0; rep_ready = 1'b1;
            step();
            rep_ready = 1'b0;
            chk(rep_valid == 1'b0, "R7 reply cleared", int'(rep_valid), 0);
            chk(hdr_ready == 1'b1, "R7 ready back", int'(hdr_ready), 1);
        end
        step();
        chk(verdict_valid == 1'b0, "R8 idle no verdict", int'(verdict_valid), 0);
    endtask

    task automatic sweep(input string req);
        for (int s = 0; s < NS; s++)
            for (int f = 0; f < MODV; f++)
                send(s, f, req);
    endtask

    initial begin
        for (int s = 0; s < NS; s++) exp_cnt[s] = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk(hdr_ready == 1'b1, "R1 ready", int'(hdr_ready), 1);
        chk(verdict_valid == 1'b0, "R1 verdict", int'(verdict_valid), 0);
        chk(rep_valid == 1'b0, "R1 reply", int'(rep_valid), 0);
        sweep("R1 R2 R3 zero counters");
        // R4: uneven commits
        for (int k = 0; k < 3; k++) commit(1);
        commit(2);
        sweep("R4 after commits");
        // R4: passes without commit do not advance
        send(0, exp_cnt[0], "R4 pass no commit a");
        send(0, exp_cnt[0], "R4 pass no commit b");
        // R5: wrap on slot 3
        for (int k = 0; k < MODV - 1; k++) commit(3);
        send(3, MODV - 1, "R5 at max");
        commit(3);
        send(3, 0, "R5 wrapped zero");
        send(3, MODV - 1, "R5 max rejected");
        sweep("R5 R4 final");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule